// File: doc/BRIEF.md
# Serial Byte Transmitter with Control/Status Register

This block is the sending side of an asynchronous serial port. Software or a DMA engine places one byte at a time in a single-entry holding buffer. When transmission is enabled and the shift stage is free, the byte moves into a shift register and goes out on the serial line as a framed character. A free-running baud counter reloads from a programmable divisor and paces every bit. Each time it passes through zero it latches a sticky flag.

One byte-wide register holds the configuration and status bits. The bits are: DMA enable, buffer empty, the sticky zero-count flag, transmit enable, and a loop-back echo mode. In echo mode the serial output follows the receive input. Each status bit has its own reset value and clear rule. A DMA request is raised whenever DMA mode is on and the buffer is empty. An acknowledge cycle delivers the byte exactly as a buffer write would.

Top module: `sertx_core`

## Requirements
- R1: Register bit map: bit 0 DMA enable, bit 1 buffer empty, bit 2 zero-count flag, bit 3 transmit enable, bit 4 echo mode, bits 7:5 read 0. While reset is held, the register reads 8'h02, `txd` is 1 and `dma_req` is 0.
- R2: The buffer-empty bit reads 0 in the cycle after a buffer write. It reads 1 again after the byte has moved into the shift register.
- R3: The baud counter counts down from `baud_div` to 0, so a zero is reached every `baud_div`+1 clocks. Each zero sets bit 2, which then stays set. Writing 1 to bit 2 clears it, and writing 0 to bit 2 leaves it unchanged. If a zero arrives in the same cycle as a clear, the set wins.
- R4: While transmit enable is 0 and echo mode is off, no frame starts and `txd` stays at 1, even when the buffer holds a byte.
- R5: While echo mode is on, `txd` equals `rx_in` within the same cycle.
- R6: A frame is one start bit of 0, eight data bits sent least significant first, and one stop bit of 1. Each bit lasts `baud_div`+1 clocks.
- R7: `dma_req` is 1 exactly when DMA enable and buffer empty are both 1. A cycle with `dma_ack` high writes `dma_data` into the buffer, and that write has priority over `buf_wr`.
- R8: If a byte is waiting when a stop bit ends, its start bit follows with no gap. The starts of consecutive frames are then exactly 10 bit times apart.
- R9: Writes to bit 1 and to bits 7:5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| buf_wr | input | 1 | Buffer write strobe |
| buf_wdata | input | 8 | Byte to place in the buffer |
| baud_div | input | 16 | Baud reload value; a bit lasts baud_div+1 clocks |
| dma_req | output | 1 | DMA request: buffer empty and DMA enabled |
| dma_ack | input | 1 | DMA acknowledge, writes dma_data into the buffer |
| dma_data | input | 8 | Byte delivered by the DMA engine |
| rx_in | input | 1 | Receive line, routed to txd in echo mode |
| txd | output | 1 | Serial data output |

## Verification
Framing is checked with bytes 0x3C, 0x55, 0xA3, 0x00, 0xFF and 0x81, plus three DMA-supplied bytes. Alternating and asymmetric patterns expose bit-order and off-by-one-bit errors. All-zero and all-one bytes show whether start and stop bits are distinguished from data. The frames are written back to back, and measuring the spacing of their start bits shows whether the shifter reloads at the stop boundary or inserts an idle bit. A byte written while transmission is disabled, and a toggling receive line in echo mode, test the output gating. A slow divisor measures the zero-count period and the write-1/write-0 clear rule.

// File: rtl/sertx_pkg.sv
// Package: shared bit positions of the control/status register and frame sizes.
// Assumes an 8-bit data character with one start and one stop bit.
package sertx_pkg;
    localparam int CHAR_W   = 8;
    localparam int FRAME_W  = CHAR_W + 2;
    localparam int B_DMA    = 0;
    localparam int B_EMPTY  = 1;
    localparam int B_ZERO   = 2;
    localparam int B_TXEN   = 3;
    localparam int B_ECHO   = 4;
endpackage

// File: rtl/sertx_baud.sv
// Baud reload counter: counts down from the divisor and pulses tick for one
// clock each time it sits at zero, reloading the divisor on that clock.
// Assumes the divisor is sampled only at reload; changes take effect at next zero.
module sertx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == '0);

    // Down-count with reload on zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick)   cnt <= div;
        else             cnt <= cnt - 1'b1;
    end

    AST_RELOAD_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(div)));  // R3
endmodule

// File: rtl/sertx_hold.sv
// Single-entry holding buffer with full flag. A write always stores the byte;
// a take by the shifter empties it unless a write lands in the same clock.
// Assumes the caller has already merged the DMA and register write paths.
module sertx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    // Buffer contents and occupancy; a write wins over a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr) begin
            full <= 1'b1;
            data <= wdata;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    AST_WR_FILLS:    assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> full);                   // R2
    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr) |=> !full);       // R2
endmodule

// File: rtl/sertx_shift.sv
// Frame shifter: on a baud tick, loads {stop, data, start} when free, enabled
// and a byte is waiting, then shifts one bit per tick, LSB first.
// Assumes the tick is one clock wide; loads only on ticks so bits align to them.
module sertx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         tx_en,
    input  logic         have_byte,
    input  logic [W-1:0] byte_in,
    output logic         take,
    output logic         busy,
    output logic         bit_out
);
    localparam int FW = W + 2;
    localparam int CW = $clog2(FW + 1);

    logic [FW-1:0] sh;
    logic [CW-1:0] left;
    logic          free;

    assign free    = !busy || (left == CW'(1));
    assign take    = tick && free && tx_en && have_byte;
    assign bit_out = sh[0];

    // Load a new frame or advance the current one on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
        end else if (take) begin
            busy <= 1'b1;
            sh   <= {1'b1, byte_in, 1'b0};
            left <= CW'(FW);
        end else if (tick && busy) begin
            if (left == CW'(1)) busy <= 1'b0;
            sh   <= {1'b1, sh[FW-1:1]};
            left <= left - 1'b1;
        end
    end

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_en));          // R4
    AST_START_LOW:      assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (busy && !bit_out));            // R6
endmodule

// File: rtl/sertx_core.sv
// Serial transmitter top: control/status register, DMA request gating,
// output mux for echo mode, and instances of baud counter, buffer and shifter.
// Assumes a single register address; reads are combinational.
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             buf_wr,
    input  logic [7:0]       buf_wdata,
    input  logic [DIV_W-1:0] baud_div,
    output logic             dma_req,
    input  logic             dma_ack,
    input  logic [7:0]       dma_data,
    input  logic             rx_in,
    output logic             txd
);
    logic        tick, take, busy, bit_out, full;
    logic        dma_en, tx_en, echo_en, zc;
    logic        hw_wr;
    logic [7:0]  hw_data, held;
    logic [3:0]  unused_wbits;

    assign unused_wbits = {reg_wdata[7:5], reg_wdata[B_EMPTY]};
    assign hw_wr   = buf_wr || dma_ack;
    assign hw_data = dma_ack ? dma_data : buf_wdata;
    assign dma_req = dma_en && !full;

    sertx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    sertx_hold #(.W(CHAR_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr(hw_wr), .wdata(hw_data),
        .take(take), .full(full), .data(held)
    );

    sertx_shift #(.W(CHAR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en),
        .have_byte(full), .byte_in(held), .take(take),
        .busy(busy), .bit_out(bit_out)
    );

    // Writable control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_en  <= 1'b0;
            tx_en   <= 1'b0;
            echo_en <= 1'b0;
        end else if (reg_wr) begin
            dma_en  <= reg_wdata[B_DMA];
            tx_en   <= reg_wdata[B_TXEN];
            echo_en <= reg_wdata[B_ECHO];
        end
    end

    // Sticky zero-count flag: set on tick, write-1-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                          zc <= 1'b0;
        else if (tick)                       zc <= 1'b1;
        else if (reg_wr && reg_wdata[B_ZERO]) zc <= 1'b0;
    end

    // Register read view.
    always_comb begin
        reg_rdata          = '0;
        reg_rdata[B_DMA]   = dma_en;
        reg_rdata[B_EMPTY] = !full;
        reg_rdata[B_ZERO]  = zc;
        reg_rdata[B_TXEN]  = tx_en;
        reg_rdata[B_ECHO]  = echo_en;
    end

    // Output select: echo path, active frame bit, or idle mark.
    always_comb begin
        if (echo_en)   txd = rx_in;
        else if (busy) txd = bit_out;
        else           txd = 1'b1;
    end

    AST_IDLE_MARK:  assert property (@(posedge clk) disable iff (!rst_n)
        (!echo_en && !busy) |-> txd);                       // R4
    AST_ZC_STICKY:  assert property (@(posedge clk) disable iff (!rst_n)
        (zc && !(reg_wr && reg_wdata[B_ZERO])) |=> zc);     // R3
    AST_DMA_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
        dma_ack |=> !dma_req);                              // R7
endmodule

// File: tb/tb_sertx_core.sv
module tb_sertx_core;
    localparam int CLK_P    = 10;
    localparam int DIV      = 7;
    localparam int BITT     = DIV + 1;
    localparam int DIV_SLOW = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        buf_wr = 1'b0;
    logic [7:0]  buf_wdata = '0;
    logic [15:0] baud_div = 16'(DIV);
    logic        dma_req;
    logic        dma_ack = 1'b0;
    logic [7:0]  dma_data = '0;
    logic        rx_in = 1'b1;
    logic        txd;

    int   errs = 0, checks = 0, cyc = 0;
    logic mon_on = 1'b0;
    logic [7:0] exp_q[$];
    int   starts[$];

    sertx_core dut (.*);

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // Driver: waits for an empty buffer, writes the byte, records expectation.
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        while (!reg_rdata[1]) @(negedge clk);
        buf_wr = 1'b1; buf_wdata = b; exp_q.push_back(b);
        @(negedge clk); buf_wr = 1'b0;
    endtask

    // Monitor: finds start bits, samples mid-bit, compares against the queue.
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_on && prev && !txd) begin
                logic [7:0] got;
                logic frm_ok;
                starts.push_back(cyc);
                repeat (BITT/2 - 1) @(negedge clk);
                frm_ok = (txd == 1'b0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITT) @(negedge clk);
                    got[i] = txd;
                end
                repeat (BITT) @(negedge clk);
                frm_ok = frm_ok && txd;
                if (exp_q.size() == 0) chk(0, "R6 unexpected frame", got, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(frm_ok && got == e, "R6 frame", {frm_ok, got}, {1'b1, e});
                end
            end
            prev = txd;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int n;
        // R1 reset state
        repeat (4) @(negedge clk);
        chk(reg_rdata == 8'h02, "R1 reset reg", reg_rdata, 8'h02);
        chk(txd == 1'b1 && dma_req == 1'b0, "R1 reset outputs", {txd, dma_req}, 2'b10);
        rst_n = 1'b1;

        // R2/R4: write while disabled
        @(negedge clk); buf_wr = 1'b1; buf_wdata = 8'h3C;
        @(negedge clk); buf_wr = 1'b0;
        chk(reg_rdata[1] == 1'b0, "R2 empty clears", reg_rdata[1], 0);
        n = 0;
        repeat (60) begin @(negedge clk); if (!txd) n++; end
        chk(n == 0 && !reg_rdata[1], "R4 idle while disabled", n, 0);

        // R5 echo
        wr_reg(8'h10);
        foreach (exp_q[i]) ;
        for (int k = 0; k < 4; k++) begin
            rx_in = k[0];
            #1;
            chk(txd == rx_in, "R5 echo", txd, rx_in);
        end
        rx_in = 1'b1;
        wr_reg(8'h00);

        // R9 read-only bits
        wr_reg(8'hE0);
        chk((reg_rdata & 8'hFB) == 8'h00, "R9 ro bits ignore write", reg_rdata & 8'hFB, 8'h00);

        // R3 zero-count period and clear rule
        baud_div = 16'(DIV_SLOW);
        repeat (250) @(negedge clk);
        wr_reg(8'h04);
        while (!reg_rdata[2]) @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 8'h04;
        @(negedge clk); reg_wr = 1'b0;
        chk(reg_rdata[2] == 1'b0, "R3 write-1 clears", reg_rdata[2], 0);
        n = 0;
        while (!reg_rdata[2] && n < 1000) begin @(negedge clk); n++; end
        chk(n == DIV_SLOW, "R3 zero period", n, DIV_SLOW);
        wr_reg(8'h00);
        chk(reg_rdata[2] == 1'b1, "R3 write-0 keeps", reg_rdata[2], 1);
        baud_div = 16'(DIV);
        repeat (300) @(negedge clk);

        // R6/R2/R8 transmission
        mon_on = 1'b1;
        exp_q.push_back(8'h3C);
        wr_reg(8'h08);
        n = 0;
        while (!reg_rdata[1] && n < 100) begin @(negedge clk); n++; end
        chk(reg_rdata[1] == 1'b1, "R2 empty sets on load", reg_rdata[1], 1);
        send_byte(8'h55);
        send_byte(8'hA3);
        send_byte(8'h00);
        send_byte(8'hFF);
        send_byte(8'h81);
        n = 0;
        while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
        for (int i = 1; i < starts.size(); i++)
            chk(starts[i] - starts[i-1] == 10*BITT, "R8 back-to-back spacing",
                starts[i] - starts[i-1], 10*BITT);

        // R7 DMA
        wr_reg(8'h09);
        chk(dma_req == 1'b1, "R7 request when empty", dma_req, 1);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] d;
            d = 8'h1F + 8'(k * 8'h31);
            n = 0;
            while (!dma_req && n < 500) begin @(negedge clk); n++; end
            dma_ack = 1'b1; dma_data = d; buf_wdata = 8'hEE; exp_q.push_back(d);
            @(negedge clk); dma_ack = 1'b0;
            chk(dma_req == 1'b0, "R7 request drops after ack", dma_req, 0);
        end
        n = 0;
        while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
        chk(exp_q.size() == 0, "R7 dma bytes sent", exp_q.size(), 0);
        wr_reg(8'h08);
        chk(dma_req == 1'b0, "R7 request off when disabled", dma_req, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule